// File: doc/BRIEF.md
# Dual Wiper Register Bank Controller

This block holds the register space that sits behind a serial control interface for a pair of 8-bit potentiometer wipers. The space has three parts. The non-volatile part holds one initial value for each wiper and thirteen general-purpose bytes. The volatile part holds the two live wiper codes. A control register selects which copy a wiper address reaches and whether the wipers are in shutdown.

The serial engine sees a simple request port. One cycle of `bus_valid` carries a read or a write, and a pulse on `bus_stop` marks the end of a transaction. A write to a non-volatile byte is held as pending until the stop. At the stop the byte is committed, and a self-timed busy window begins. While that window is open, every write is refused.

After reset the wipers sit at mid-scale. A fixed number of cycles later they are reloaded from the stored initial values, and `ready` rises. Non-volatile contents survive a reset.

Top module: `dual_wiper_regbank`

## Requirements
- R1: While reset is held and until `ready` rises, both wiper outputs are 80h. `ready` rises on the RECALL_CYCLES-th rising edge after reset is released. In that same edge both wipers take the stored initial values, and `ready` then stays high.
- R2: After reset the control byte at address 10h reads 40h: bit 7 (volatile select) is 0 and bit 6 (run) is 1. `shutdown` is 0.
- R3: With control bit 7 set, a write to address 0 or 1 changes only that wiper, one cycle later. The stored initial value stays unchanged, no busy window follows the stop, and a read returns the wiper code.
- R4: With control bit 7 clear, a write to address 0 or 1 updates the wiper one cycle later. The same byte is committed as the initial value at the following stop, and reads of address 0 or 1 return the initial value.
- R5: A stop that follows an accepted non-volatile write raises `nv_busy` on the next edge. `nv_busy` stays high for exactly NV_CYCLES cycles, and control bit 5 reads as the busy state.
- R6: While `nv_busy` is high, writes to wipers, to the control byte and to non-volatile bytes are all ignored.
- R7: Addresses 02h to 0Eh are general-purpose non-volatile bytes. They read back the value committed at the last stop.
- R8: Address 0Fh and addresses 11h to 1Fh read 00h. Writes to them have no effect and start no busy window.
- R9: When control bit 6 is 0, `shutdown` is 1. Control bits 4 to 0 always read 0, and a write to bit 5 has no effect.
- R10: Read data appears on `rd_data` at the rising edge that follows the edge accepting the read.
- R11: Requests and stops that arrive while `ready` is low are ignored.
- R12: Non-volatile contents are kept across reset, and the next recall loads the newly stored initial values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, starts the recall |
| bus_valid | input | 1 | One-cycle request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_stop | input | 1 | End-of-transaction pulse |
| rd_data | output | 8 | Read data, one cycle after the request |
| wiper0_code | output | 8 | Live code of wiper 0 |
| wiper1_code | output | 8 | Live code of wiper 1 |
| shutdown | output | 1 | 1 while the wipers are shut down |
| nv_busy | output | 1 | Non-volatile write cycle in progress |
| ready | output | 1 | Recall finished, requests accepted |

## Verification
Some internal faults appear at the wiper ports within one cycle: a wrong volatile-select routing, or a write that slips through the lockout. A lost or misrouted pending byte stays hidden until a later read or until the next reset recall. For that reason every write is followed by a stop, a timed busy window and a read-back, and reset is repeated once non-volatile data has been stored. A busy counter with a wrong length shows as a window one cycle too short or too long, and the cycle-by-cycle count of `nv_busy` catches it.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
  localparam int ADR_GP_FIRST = 2;
  localparam int ADR_GP_LAST  = 14;
  localparam int ADR_CTRL     = 16;

  localparam int CTL_VOLSEL = 7;
  localparam int CTL_RUN    = 6;
  localparam int CTL_BUSY   = 5;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_NV   = 2'd1,
    SRC_REG  = 2'd2
  } rd_src_e;
endpackage

// File: rtl/wrb_nv_store.sv
module wrb_nv_store #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 5,
  parameter int NUM_IV   = 2,
  parameter int NV_DEPTH = 15
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     re,
  input  logic [ADDR_W-1:0]        raddr,
  output logic [DATA_W-1:0]        rdata,
  output logic [NUM_IV*DATA_W-1:0] iv_flat
);
  localparam int IDX_W   = $clog2(NV_DEPTH);
  localparam int MEM_LEN = 1 << IDX_W;

  logic [DATA_W-1:0] gp_mem [MEM_LEN];
  logic [DATA_W-1:0] iv_q   [NUM_IV];
  logic [DATA_W-1:0] gp_q;
  logic [DATA_W-1:0] iv_rd_q;
  logic              iv_sel_q;

  wire [IDX_W-1:0] widx = waddr[IDX_W-1:0];
  wire [IDX_W-1:0] ridx = raddr[IDX_W-1:0];
  wire             w_iv = int'(waddr) < NUM_IV;
  wire             r_iv = int'(raddr) < NUM_IV;

  // Power-on contents; storage is not touched by reset.
  initial begin
    for (int i = 0; i < MEM_LEN; i++) gp_mem[i] = '0;
    for (int i = 0; i < NUM_IV; i++) iv_q[i] = '0;
  end

  // Block-RAM style port: one synchronous write, one synchronous read.
  always_ff @(posedge clk) begin
    if (we && !w_iv) gp_mem[widx] <= wdata;
    if (re) gp_q <= gp_mem[ridx];
  end

  genvar g;
  generate
    for (g = 0; g < NUM_IV; g++) begin : g_iv
      always_ff @(posedge clk) begin
        if (we && w_iv && (int'(waddr) == g)) iv_q[g] <= wdata;
      end
      assign iv_flat[g*DATA_W +: DATA_W] = iv_q[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (re) begin
      iv_sel_q <= r_iv;
      iv_rd_q  <= iv_q[ridx[$clog2(NUM_IV)-1:0]];
    end
  end

  assign rdata = iv_sel_q ? iv_rd_q : gp_q;
endmodule

// File: rtl/wrb_cycle_timer.sv
module wrb_cycle_timer #(
  parameter int CYCLES = 2000000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cnt_q <= CNT_W'(CYCLES - 1);
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else cnt_q <= cnt_q - 1'b1;
    end
  end

  // R5
  start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

  // R5
  busy_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/wrb_recall_seq.sv
module wrb_recall_seq #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic fire,
  output logic ready
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b0;
      cnt_q <= CNT_W'(CYCLES - 1);
    end else if (!ready) begin
      if (cnt_q == '0) ready <= 1'b1;
      else cnt_q <= cnt_q - 1'b1;
    end
  end

  assign fire = !rst && !ready && (cnt_q == '0);

  // R1
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);
endmodule

// File: rtl/dual_wiper_regbank.sv
module dual_wiper_regbank
  import wrb_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int ADDR_W        = 5,
  parameter int NUM_WIPERS    = 2,
  parameter int NV_CYCLES     = 2000000,
  parameter int RECALL_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_stop,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] wiper0_code,
  output logic [DATA_W-1:0] wiper1_code,
  output logic              shutdown,
  output logic              nv_busy,
  output logic              ready
);
  localparam int NV_DEPTH = ADR_GP_LAST + 1;
  localparam int WIDX_W   = (NUM_WIPERS > 1) ? $clog2(NUM_WIPERS) : 1;
  localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

  logic [DATA_W-1:0]            wiper_q [NUM_WIPERS];
  logic [NUM_WIPERS*DATA_W-1:0] iv_flat;
  logic                         volsel_q, run_q;
  logic                         pend_q;
  logic [ADDR_W-1:0]            pend_addr_q;
  logic [DATA_W-1:0]            pend_data_q;
  rd_src_e                      src_q;
  logic [DATA_W-1:0]            reg_rd_q;
  logic [DATA_W-1:0]            nv_rdata;
  logic [DATA_W-1:0]            ctl_byte;
  logic                         recall_fire;

  // Address decode
  wire hit_wiper = int'(bus_addr) < NUM_WIPERS;
  wire hit_gp    = (int'(bus_addr) >= ADR_GP_FIRST) && (int'(bus_addr) <= ADR_GP_LAST);
  wire hit_ctl   = int'(bus_addr) == ADR_CTRL;
  wire [WIDX_W-1:0] widx = bus_addr[WIDX_W-1:0];

  wire accept    = ready && bus_valid;
  wire wr_ok     = accept && bus_write && !nv_busy;
  wire rd_en     = accept && !bus_write;
  wire nv_target = hit_gp || (hit_wiper && !volsel_q);
  wire stop_fire = ready && bus_stop && pend_q;

  wrb_recall_seq #(.CYCLES(RECALL_CYCLES)) recall_i (
    .clk   (clk),
    .rst   (rst),
    .fire  (recall_fire),
    .ready (ready)
  );

  wrb_cycle_timer #(.CYCLES(NV_CYCLES)) timer_i (
    .clk   (clk),
    .rst   (rst),
    .start (stop_fire),
    .busy  (nv_busy)
  );

  wrb_nv_store #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .NUM_IV   (NUM_WIPERS),
    .NV_DEPTH (NV_DEPTH)
  ) store_i (
    .clk     (clk),
    .we      (stop_fire),
    .waddr   (pend_addr_q),
    .wdata   (pend_data_q),
    .re      (rd_en),
    .raddr   (bus_addr),
    .rdata   (nv_rdata),
    .iv_flat (iv_flat)
  );

  // Live wiper registers
  genvar g;
  generate
    for (g = 0; g < NUM_WIPERS; g++) begin : g_wiper
      always_ff @(posedge clk) begin
        if (rst) wiper_q[g] <= MID_CODE;
        else if (recall_fire) wiper_q[g] <= iv_flat[g*DATA_W +: DATA_W];
        else if (wr_ok && hit_wiper && (int'(widx) == g)) wiper_q[g] <= bus_wdata;
      end
    end
  endgenerate

  // Control register
  always_ff @(posedge clk) begin
    if (rst) begin
      volsel_q <= 1'b0;
      run_q    <= 1'b1;
    end else if (wr_ok && hit_ctl) begin
      volsel_q <= bus_wdata[CTL_VOLSEL];
      run_q    <= bus_wdata[CTL_RUN];
    end
  end

  always_comb begin
    ctl_byte             = '0;
    ctl_byte[CTL_VOLSEL] = volsel_q;
    ctl_byte[CTL_RUN]    = run_q;
    ctl_byte[CTL_BUSY]   = nv_busy;
  end

  // Pending non-volatile byte, committed at the stop
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else if (stop_fire) begin
      pend_q <= 1'b0;
    end else if (wr_ok && nv_target) begin
      pend_q      <= 1'b1;
      pend_addr_q <= bus_addr;
      pend_data_q <= bus_wdata;
    end
  end

  // Read path
  always_ff @(posedge clk) begin
    if (rst) begin
      src_q    <= SRC_ZERO;
      reg_rd_q <= '0;
    end else if (rd_en) begin
      if (hit_wiper && volsel_q) begin
        src_q    <= SRC_REG;
        reg_rd_q <= wiper_q[widx];
      end else if (nv_target) begin
        src_q <= SRC_NV;
      end else if (hit_ctl) begin
        src_q    <= SRC_REG;
        reg_rd_q <= ctl_byte;
      end else begin
        src_q <= SRC_ZERO;
      end
    end
  end

  always_comb begin
    case (src_q)
      SRC_NV:  rd_data = nv_rdata;
      SRC_REG: rd_data = reg_rd_q;
      default: rd_data = '0;
    endcase
  end

  assign wiper0_code = wiper_q[0];
  assign wiper1_code = wiper_q[NUM_WIPERS-1];
  assign shutdown    = !run_q;

  // R1
  wiper_mid_chk: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (wiper0_code == MID_CODE && wiper1_code == MID_CODE));

  // R1
  recall_load_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (wiper0_code == iv_flat[DATA_W-1:0]));

  // R6
  ctl_lock_chk: assert property (@(posedge clk) disable iff (rst)
    nv_busy |=> ($stable(volsel_q) && $stable(run_q)));

  // R6
  wiper_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (nv_busy && !recall_fire) |=> ($stable(wiper0_code) && $stable(wiper1_code)));

  // R5
  stop_busy_chk: assert property (@(posedge clk) disable iff (rst)
    stop_fire |=> nv_busy);
endmodule

// File: tb/dual_wiper_regbank_tb.sv
module dual_wiper_regbank_tb_top;
  localparam int NVC = 20;
  localparam int RCL = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_valid = 1'b0, bus_write = 1'b0, bus_stop = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] rd_data, wiper0_code, wiper1_code;
  logic       shutdown, nv_busy, ready;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Bench model
  logic [7:0] m_iv [2];
  logic [7:0] m_gp [16];
  logic [7:0] m_w  [2];
  logic       m_vol, m_run, m_pend;

  always #2.5 clk = ~clk;

  dual_wiper_regbank #(.NV_CYCLES(NVC), .RECALL_CYCLES(RCL)) dut_i (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_stop(bus_stop),
    .rd_data(rd_data), .wiper0_code(wiper0_code), .wiper1_code(wiper1_code),
    .shutdown(shutdown), .nv_busy(nv_busy), .ready(ready)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input int a);
    if (a < 2) return m_vol ? m_w[a] : m_iv[a];
    if (a <= 14) return m_gp[a];
    if (a == 16) return {m_vol, m_run, 6'b0};
    return 8'h00;
  endfunction

  task automatic do_write(input int a, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 5'(a); bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic do_read(input int a, output logic [7:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = 5'(a);
    @(negedge clk);
    bus_valid = 0;
    d = rd_data;
  endtask

  task automatic do_stop(output int busy_len);
    @(negedge clk);
    bus_stop = 1;
    @(negedge clk);
    bus_stop = 0;
    busy_len = 0;
    while (nv_busy && busy_len < 4 * NVC) begin
      busy_len++;
      @(negedge clk);
    end
  endtask

  // Model update for an accepted write (busy assumed low)
  task automatic model_write(input int a, input logic [7:0] d);
    if (a < 2) begin
      m_w[a] = d;
      if (!m_vol) begin m_iv[a] = d; m_pend = 1; end
    end else if (a <= 14) begin
      m_gp[a] = d; m_pend = 1;
    end else if (a == 16) begin
      m_vol = d[7]; m_run = d[6];
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    m_vol = 0; m_run = 1; m_pend = 0;
  endtask

  initial begin
    logic [7:0] rd;
    int blen;
    int dummy;
    dummy = $urandom(32'd4711);
    for (int i = 0; i < 2; i++) m_iv[i] = 8'h00;
    for (int i = 0; i < 16; i++) m_gp[i] = 8'h00;

    // R1: first recall with power-on contents
    apply_reset();
    for (int i = 0; i < RCL - 1; i++) begin
      @(negedge clk);
      chk("R1 ready low during recall", {7'b0, ready}, 8'h00);
      chk("R1 wiper0 mid during recall", wiper0_code, 8'h80);
    end
    @(negedge clk);
    chk("R1 ready high", {7'b0, ready}, 8'h01);
    chk("R1 wiper0 recalled", wiper0_code, 8'h00);
    chk("R1 wiper1 recalled", wiper1_code, 8'h00);
    m_w[0] = 0; m_w[1] = 0;

    // R2
    do_read(16, rd);
    chk("R2 control reset value", rd, 8'h40);
    chk("R2 shutdown low", {7'b0, shutdown}, 8'h00);

    // R4: non-volatile wiper write
    do_write(0, 8'h3C); model_write(0, 8'h3C);
    chk("R4 wiper0 immediate", wiper0_code, 8'h3C);
    chk("R4 busy before stop", {7'b0, nv_busy}, 8'h00);
    do_stop(blen); m_pend = 0;
    chk("R5 busy window length", 8'(blen), 8'(NVC));
    do_read(0, rd);
    chk("R4 read initial value", rd, 8'h3C);
    chk("R10 read latency data", rd, exp_rd(0));

    // R3: volatile-only access
    do_write(16, 8'hC0); model_write(16, 8'hC0);
    do_write(1, 8'hA5); model_write(1, 8'hA5);
    chk("R3 wiper1 updated", wiper1_code, 8'hA5);
    do_stop(blen);
    chk("R3 no busy after volatile write", 8'(blen), 8'h00);
    do_read(1, rd);
    chk("R3 read wiper", rd, 8'hA5);
    do_write(16, 8'h40); model_write(16, 8'h40);
    do_read(1, rd);
    chk("R3 initial value untouched", rd, 8'h00);

    // R6: lockout during busy
    do_write(5, 8'h77); model_write(5, 8'h77);
    @(negedge clk); bus_stop = 1; @(negedge clk); bus_stop = 0; m_pend = 0;
    chk("R5 busy raised", {7'b0, nv_busy}, 8'h01);
    do_read(16, rd);
    chk("R5 control busy bit", rd, 8'h60);
    do_write(16, 8'h80);
    chk("R6 control write ignored", {7'b0, shutdown}, 8'h00);
    do_write(0, 8'h99);
    chk("R6 wiper write ignored", wiper0_code, 8'h3C);
    do_write(6, 8'h12);
    blen = 0;
    while (nv_busy && blen < 4 * NVC) begin blen++; @(negedge clk); end
    do_read(16, rd);
    chk("R6 control unchanged", rd, 8'h40);
    do_read(6, rd);
    chk("R6 nv write ignored", rd, 8'h00);
    do_read(5, rd);
    chk("R7 general byte read back", rd, 8'h77);

    // R8: reserved and unmapped
    do_write(15, 8'hFF);
    do_stop(blen);
    chk("R8 no busy on reserved", 8'(blen), 8'h00);
    do_read(15, rd);  chk("R8 reserved reads zero", rd, 8'h00);
    do_read(17, rd);  chk("R8 11h reads zero", rd, 8'h00);
    do_read(31, rd);  chk("R8 1Fh reads zero", rd, 8'h00);

    // R9: shutdown and fixed bits
    do_write(16, 8'h3F); model_write(16, 8'h3F);
    chk("R9 shutdown asserted", {7'b0, shutdown}, 8'h01);
    do_read(16, rd);
    chk("R9 low bits read zero", rd, 8'h00);
    do_write(16, 8'h40); model_write(16, 8'h40);
    chk("R9 shutdown released", {7'b0, shutdown}, 8'h00);

    // R11, R12: reset keeps storage; requests during recall ignored
    apply_reset();
    do_write(0, 8'h11);
    chk("R11 write ignored during recall", wiper0_code, 8'h80);
    @(negedge clk); bus_stop = 1; @(negedge clk); bus_stop = 0;
    chk("R11 stop ignored during recall", {7'b0, nv_busy}, 8'h00);
    for (int i = 0; i < RCL - 5; i++) @(negedge clk);
    chk("R1 ready still low", {7'b0, ready}, 8'h00);
    @(negedge clk);
    chk("R1 ready after second recall", {7'b0, ready}, 8'h01);
    chk("R12 wiper0 recalled stored", wiper0_code, 8'h3C);
    chk("R12 wiper1 recalled stored", wiper1_code, 8'h00);
    m_w[0] = m_iv[0]; m_w[1] = m_iv[1];
    do_read(5, rd);
    chk("R12 general byte kept", rd, 8'h77);

    // Random mix
    for (int it = 0; it < 120; it++) begin
      int sel, a;
      logic [7:0] d;
      sel = int'($urandom % 8);
      if (sel == 0) a = 16;
      else if (sel == 1) a = ($urandom % 2 == 0) ? 15 : int'($urandom_range(31, 17));
      else a = int'($urandom_range(14, 0));
      d = 8'($urandom);
      m_pend = 0;
      do_write(a, d); model_write(a, d);
      chk("R3 R4 random wiper0", wiper0_code, m_w[0]);
      chk("R3 R4 random wiper1", wiper1_code, m_w[1]);
      chk("R9 random shutdown", {7'b0, shutdown}, {7'b0, !m_run});
      do_stop(blen);
      chk("R5 random busy length", 8'(blen), m_pend ? 8'(NVC) : 8'h00);
      m_pend = 0;
      a = ($urandom % 4 == 0) ? 16 : int'($urandom_range(31, 0));
      do_read(a, rd);
      chk("R7 R10 random read", rd, exp_rd(a));
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule